// File: doc/BRIEF.md
# Core Halt Power-State Controller

This block tracks the power state of one processor core around the halt instruction. The core is either running, halted, parked in stop-grant while the system holds stop-clock, or inside system-management mode (SMM) servicing an SMI. A one-cycle pulse reports that a halt instruction has executed. Level or pulse wake inputs report SMI, INIT and the maskable and non-maskable interrupt sources. A return strobe marks the end of the SMM handler.

Two transitions can lead back to the halted state: stop-clock being released, and the SMM handler returning. To support them, the controller records in a single bit whether the core was halted at the moment it left for stop-grant or SMM. A core halted before the interruption can then go back to the halted state instead of always resuming execution. The block does not model instruction execution or handler code. It only keeps the state and the return target.

All pins are plain control and status levels sampled on the clock edge. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `core_halt_ctrl`

## Requirements
- R1: In RUN (code 0), a `halt_exec` pulse moves the state to HALT (code 1) at the next clock edge when no INIT, SMI or stop-clock is present in the same cycle.
- R2: In HALT, any set bit of `wake_irq` moves the state to RUN at the next edge. A `halt_exec` pulse while in HALT has no effect.
- R3: `rst` is synchronous and active-high. At the next edge it forces RUN and clears the saved halt bit, whatever the state and the other inputs.
- R4: Below reset, the priority is INIT, then SMI, then stop-clock, then interrupt and halt events. INIT in any state moves the state to RUN at the next edge.
- R5: `stpclk_req` moves RUN or HALT to STOPGNT (code 2). While it stays high, the state stays STOPGNT, and SMI, `wake_irq`, `halt_exec` and `smm_return` are ignored.
- R6: When `stpclk_req` is low in STOPGNT, the next edge returns the state to HALT if the core was halted when stop-grant was entered, and to RUN otherwise.
- R7: SMI moves RUN or HALT to SMM (code 3). In SMM the state holds until `smm_return` is seen, and `stpclk_req`, `wake_irq` and `halt_exec` are ignored.
- R8: `smm_return` in SMM moves the state to HALT only if `smm_resume_halt` is 1 and the core was halted when SMM was entered. In every other case it moves the state to RUN.
- R9: `core_state` carries the encoding above, and `core_running` is 1 exactly when `core_state` is RUN. Without a triggering event the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_exec | input | 1 | Halt instruction executed this cycle |
| wake_init | input | 1 | INIT event |
| wake_smi | input | 1 | SMI event |
| wake_irq | input | IRQ_W | Interrupt wakes: bit 0 NMI, bit 1 INTR, bit 2 bus interrupt message |
| stpclk_req | input | 1 | Stop-clock level from the system |
| smm_return | input | 1 | SMM handler return strobe |
| smm_resume_halt | input | 1 | With the return strobe: resume in the halted state |
| core_state | output | 2 | 0 RUN, 1 HALT, 2 STOPGNT, 3 SMM |
| core_running | output | 1 | High while in RUN |

## Verification
Every result is due exactly one clock edge after the inputs that cause it, because the state register is the only stage between the pins and the outputs. The bench drives each input set on the falling edge. A bench function computes the next state and the saved bit from that set and the previous expected state. The bench then samples `core_state` and `core_running` on the following falling edge and compares them there. Stimulus is a fixed sequence of directed corners followed by seeded random cycles, and it runs one cycle at a time, so each expectation covers a single edge.

// File: rtl/core_halt_pkg.sv
package core_halt_pkg;
  typedef enum logic [1:0] {
    CS_RUN  = 2'd0,
    CS_HALT = 2'd1,
    CS_STOP = 2'd2,
    CS_SMM  = 2'd3
  } core_st_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_INIT = 2'd1,
    EV_SMI  = 2'd2,
    EV_IRQ  = 2'd3
  } wake_ev_e;
endpackage

// File: rtl/chc_wake_arb.sv
module chc_wake_arb
  import core_halt_pkg::*;
#(
  parameter int IRQ_W = 3
) (
  input  logic             init_i,
  input  logic             smi_i,
  input  logic [IRQ_W-1:0] irq_i,
  output wake_ev_e         ev_o
);
  logic [IRQ_W:0] any_chain;

  assign any_chain[0] = 1'b0;
  for (genvar g = 0; g < IRQ_W; g++) begin : g_or
    assign any_chain[g+1] = any_chain[g] | irq_i[g];
  end

  always_comb begin
    if (init_i)             ev_o = EV_INIT;
    else if (smi_i)         ev_o = EV_SMI;
    else if (any_chain[IRQ_W]) ev_o = EV_IRQ;
    else                    ev_o = EV_NONE;
  end

  // R4: INIT always wins the arbitration
  always_comb begin
    if (init_i) assert_init_first_R4: assert (ev_o == EV_INIT);
  end
endmodule

// File: rtl/chc_ret_track.sv
module chc_ret_track (
  input  logic clk,
  input  logic rst,
  input  logic cap_en_i,
  input  logic cap_halt_i,
  output logic was_halt_o
);
  always_ff @(posedge clk) begin
    if (rst)           was_halt_o <= 1'b0;
    else if (cap_en_i) was_halt_o <= cap_halt_i;
  end

  assert_clear_on_rst_R3: assert property (@(posedge clk)
    rst |=> !was_halt_o);

  assert_hold_target_R6: assert property (@(posedge clk) disable iff (rst)
    !cap_en_i |=> $stable(was_halt_o));
endmodule

// File: rtl/core_halt_ctrl.sv
module core_halt_ctrl
  import core_halt_pkg::*;
#(
  parameter int IRQ_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_exec,
  input  logic             wake_init,
  input  logic             wake_smi,
  input  logic [IRQ_W-1:0] wake_irq,
  input  logic             stpclk_req,
  input  logic             smm_return,
  input  logic             smm_resume_halt,
  output logic [1:0]       core_state,
  output logic             core_running
);
  core_st_e st_q, st_d;
  wake_ev_e ev;
  logic     cap_en, cap_halt, was_halt;

  chc_wake_arb #(.IRQ_W(IRQ_W)) arb_i (
    .init_i(wake_init),
    .smi_i (wake_smi),
    .irq_i (wake_irq),
    .ev_o  (ev)
  );

  chc_ret_track trk_i (
    .clk       (clk),
    .rst       (rst),
    .cap_en_i  (cap_en),
    .cap_halt_i(cap_halt),
    .was_halt_o(was_halt)
  );

  always_comb begin
    st_d     = st_q;
    cap_en   = 1'b0;
    cap_halt = (st_q == CS_HALT);
    if (ev == EV_INIT) begin
      st_d = CS_RUN;
    end else begin
      unique case (st_q)
        CS_RUN, CS_HALT: begin
          if (ev == EV_SMI) begin
            st_d   = CS_SMM;
            cap_en = 1'b1;
          end else if (stpclk_req) begin
            st_d   = CS_STOP;
            cap_en = 1'b1;
          end else if (st_q == CS_HALT && ev == EV_IRQ) begin
            st_d = CS_RUN;
          end else if (st_q == CS_RUN && halt_exec) begin
            st_d = CS_HALT;
          end
        end
        CS_STOP: begin
          if (!stpclk_req) st_d = was_halt ? CS_HALT : CS_RUN;
        end
        CS_SMM: begin
          if (smm_return) st_d = (was_halt && smm_resume_halt) ? CS_HALT : CS_RUN;
        end
        default: st_d = CS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= CS_RUN;
    else     st_q <= st_d;
  end

  assign core_state   = st_q;
  assign core_running = (st_q == CS_RUN);

  assert_reset_run_R3: assert property (@(posedge clk)
    rst |=> (core_state == 2'd0 && core_running));

  assert_halt_entry_R1: assert property (@(posedge clk) disable iff (rst)
    (core_state == 2'd0 && halt_exec && !wake_init && !wake_smi && !stpclk_req)
    |=> core_state == 2'd1);

  assert_irq_wake_R2: assert property (@(posedge clk) disable iff (rst)
    (core_state == 2'd1 && |wake_irq && !wake_init && !wake_smi && !stpclk_req)
    |=> core_state == 2'd0);

  assert_init_run_R4: assert property (@(posedge clk) disable iff (rst)
    wake_init |=> core_state == 2'd0);

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (core_state == 2'd2 && stpclk_req && !wake_init) |=> core_state == 2'd2);

  assert_smm_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (core_state == 2'd3 && !smm_return && !wake_init) |=> core_state == 2'd3);

  assert_smm_run_R8: assert property (@(posedge clk) disable iff (rst)
    (core_state == 2'd3 && smm_return && !smm_resume_halt && !wake_init)
    |=> core_state == 2'd0);
endmodule

// File: tb/core_halt_ctrl_tb.sv
module core_halt_ctrl_tb_top;
  localparam int IRQ_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_exec = 0, wake_init = 0, wake_smi = 0, stpclk_req = 0;
  logic smm_return = 0, smm_resume_halt = 0;
  logic [IRQ_W-1:0] wake_irq = '0;
  logic [1:0] core_state;
  logic core_running;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic [1:0] m_st;
  logic m_sv;

  always #2 clk = ~clk;

  core_halt_ctrl #(.IRQ_W(IRQ_W)) dut_i (
    .clk(clk), .rst(rst), .halt_exec(halt_exec), .wake_init(wake_init),
    .wake_smi(wake_smi), .wake_irq(wake_irq), .stpclk_req(stpclk_req),
    .smm_return(smm_return), .smm_resume_halt(smm_resume_halt),
    .core_state(core_state), .core_running(core_running)
  );

  // returns {saved_bit, next_state}
  function automatic logic [2:0] model_next(input logic [1:0] st, input logic sv,
      input logic r, input logic i, input logic s, input logic [IRQ_W-1:0] q,
      input logic h, input logic sc, input logic sr, input logic sb);
    if (r) return 3'b000;
    if (i) return {sv, 2'd0};
    case (st)
      2'd0, 2'd1: begin
        if (s)  return {st == 2'd1, 2'd3};
        if (sc) return {st == 2'd1, 2'd2};
        if (st == 2'd1 && |q) return {sv, 2'd0};
        if (st == 2'd0 && h)  return {sv, 2'd1};
        return {sv, st};
      end
      2'd2: return sc ? {sv, 2'd2} : {sv, (sv ? 2'd1 : 2'd0)};
      default: return sr ? {sv, ((sv && sb) ? 2'd1 : 2'd0)} : {sv, 2'd3};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] st, input logic r, input logic i,
      input logic s, input logic [IRQ_W-1:0] q, input logic h, input logic sc, input logic sr);
    if (r) return "R3";
    if (i) return "R4";
    if (st == 2'd2) return sc ? "R5" : "R6";
    if (st == 2'd3) return sr ? "R8" : "R7";
    if (s)  return "R7";
    if (sc) return "R5";
    if (st == 2'd1) return (|q) ? "R2" : "R9";
    return h ? "R1" : "R9";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic i, input logic s, input logic [IRQ_W-1:0] q,
      input logic h, input logic sc, input logic sr, input logic sb);
    logic [2:0] nx;
    string tg;
    rst = r; wake_init = i; wake_smi = s; wake_irq = q; halt_exec = h;
    stpclk_req = sc; smm_return = sr; smm_resume_halt = sb;
    nx = model_next(m_st, m_sv, r, i, s, q, h, sc, sr, sb);
    tg = tag_of(m_st, r, i, s, q, h, sc, sr);
    @(posedge clk);
    @(negedge clk);
    m_st = nx[1:0];
    m_sv = nx[2];
    check(core_state == m_st, tg, core_state, m_st);
    check(core_running == (m_st == 2'd0), "R9", core_running, m_st == 2'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    m_st = 2'd0; m_sv = 1'b0;
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, 0, 0);                       // R3 reset state
    check(core_state == 2'd0, "R3", core_state, 0);
    // directed corners
    step(0, 0, 0, 0, 1, 0, 0, 0);                       // R1 halt
    step(0, 0, 0, 0, 1, 0, 0, 0);                       // R2 halt ignored in HALT
    step(0, 0, 0, 3'b001, 0, 0, 0, 0);                  // R2 NMI wake
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 3'b100, 0, 0, 0, 0);                  // R2 bus message wake
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);                       // R5 enter stop from HALT
    step(0, 0, 1, 3'b010, 1, 1, 1, 1);                  // R5 ignored while stopped
    step(0, 0, 0, 0, 0, 0, 0, 0);                       // R6 back to HALT
    step(0, 0, 1, 0, 0, 0, 0, 0);                       // R7 SMI from HALT
    step(0, 0, 0, 3'b111, 1, 1, 0, 0);                  // R7 ignored in SMM
    step(0, 0, 0, 0, 0, 0, 1, 1);                       // R8 resume halt
    step(0, 0, 0, 3'b010, 0, 0, 0, 0);                  // R2 INTR wake
    step(0, 0, 1, 0, 0, 0, 0, 0);                       // R7 SMI from RUN
    step(0, 0, 0, 0, 0, 0, 1, 1);                       // R8 resume bit ignored from RUN
    step(0, 0, 0, 0, 0, 1, 0, 0);                       // R5 stop from RUN
    step(0, 0, 0, 0, 0, 0, 0, 0);                       // R6 back to RUN
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 1, 1, 3'b111, 0, 1, 0, 0);                  // R4 INIT beats all
    step(0, 0, 1, 0, 1, 1, 0, 0);                       // R4 SMI beats stop and halt
    step(1, 1, 0, 0, 0, 0, 1, 1);                       // R3 reset from SMM
    // seeded random
    for (int n = 0; n < 4000; n++) begin
      logic sc_next;
      sc_next = (($urandom % 8) == 0) ? ~stpclk_req : stpclk_req;
      step(($urandom % 97) == 0, ($urandom % 40) == 0, ($urandom % 12) == 0,
           IRQ_W'($urandom % 16 < 2 ? $urandom : 0), ($urandom % 4) == 0,
           sc_next, ($urandom % 4) == 0, $urandom % 2);
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule